// File: doc/BRIEF.md
# T1 Per-Channel Time-Slot Datapath Controller

This block sits between a 24-channel T1 byte stream and the system side of a line card. It handles one octet per clock when `oct_valid_i` is high. Each octet comes with its slot index (0..23) and a frame number (0..11 within a 12-frame superframe). The block looks up that slot's 8-bit control word. From that word it builds the octet sent to the line and the octet returned to the system, and both appear registered one cycle later.

For each slot, the transmit octet is taken from one of four sources: the received line octet (remote loopback), a test pattern, a shared message byte, or the system byte, which may be inverted. Robbed-bit signaling is then inserted in the least significant bit. The receive octet is either the line octet or the slot's own transmit octet (local loopback), optionally inverted. A receive test can replace it with the milliwatt sequence or send it to a self-synchronising PRBS checker.

Control words are written through a paged port. A separate write port loads the message register, and another loads the per-slot signaling RAM.

Top module: `t1_slot_ctrl`

## Requirements
- R1: A control write with `ctl_page_i`=0 and offset n (0..15) sets the word of slot n. With `ctl_page_i`=1 and offset n (0..7) it sets the word of slot 16+n. Control word fields: bit7 message, bit6 invert, bit5 remote loopback, bit4 local loopback, bit3 transmit test, bit2 receive test, bit1 signaling source, bit0 clear channel.
- R2: A control write with `ctl_page_i`=1 and offset 8..15 changes no slot's control word.
- R3: With bits 7, 5 and 3 clear, the transmit octet is `sys_tx_i`, inverted when bit6 is set. With bits 4 and 2 clear, the receive octet is `line_rx_i`, inverted when bit6 is set.
- R4: With bit7 set and bits 5 and 3 clear, the transmit octet is the last byte written through `msg_we_i`.
- R5: Bit5 set makes the transmit octet equal to `line_rx_i`, whatever the other bits are. The receive path is unaffected by bit5.
- R6: Bit4 set makes the receive source the slot's final transmit octet (after signaling insertion) instead of `line_rx_i`. Inversion by bit6 is then applied to it.
- R7: Bit3 set and bit5 clear transmits the test pattern: the milliwatt byte when `test_sel_i`=1, or the next PRBS octet when `test_sel_i`=0. This takes priority over bit7.
- R8: Bit2 set with `test_sel_i`=1 puts the milliwatt byte on `sys_rx_o`. With `test_sel_i`=0, the receive source octet is fed MSB first to the PRBS checker, and `sys_rx_o` follows R3/R6.
- R9: When bit0 is clear, the LSB of the final transmit octet is replaced in frame 5 by signaling bit A and in frame 11 by signaling bit B. Bit1=1 takes A/B from the signaling RAM (`sig_wdata_i` bit1=A, bit0=B). Bit1=0 takes them from `sig_ser_i` (bit1=A, bit0=B). When bit0 is set, nothing is replaced.
- R10: The PRBS checker loads its first 15 bits, then raises `prbs_sync_o` permanently. After that it counts each received bit differing from the XOR of the bits 15 and 14 positions earlier, saturating at 65535.
- R11: Outputs for an octet appear one clock after it is presented. `oct_valid_o` is high exactly in the cycle after `oct_valid_i`.
- R12: The milliwatt sequence is 1E 0B 0B 1E 9E 8B 8B 9E. It starts at its first byte after reset and advances one byte after each octet of slot 23.
- R13: The PRBS generator starts from all ones. Each new bit is the XOR of state bits 14 and 13, shifted in at bit 0, and the bits are emitted MSB first. It advances by 8 bits only for octets that transmit the PRBS pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_page_i | input | 1 | Control page select |
| ctl_addr_i | input | 4 | Offset within page |
| ctl_wdata_i | input | 8 | Control word data |
| msg_we_i | input | 1 | Message register write strobe |
| msg_wdata_i | input | 8 | Message byte |
| sig_we_i | input | 1 | Signaling RAM write strobe |
| sig_slot_i | input | 5 | Signaling RAM slot index |
| sig_wdata_i | input | 2 | Signaling bits A (bit1), B (bit0) |
| test_sel_i | input | 1 | 1 = milliwatt, 0 = PRBS |
| oct_valid_i | input | 1 | Octet present |
| oct_slot_i | input | 5 | Slot index 0..23 |
| oct_frame_i | input | 4 | Frame index 0..11 |
| sys_tx_i | input | 8 | System octet to transmit |
| line_rx_i | input | 8 | Received line octet |
| sig_ser_i | input | 2 | Serial signaling bits A, B for the slot |
| oct_valid_o | output | 1 | Output octet valid |
| line_tx_o | output | 8 | Octet to the line |
| sys_rx_o | output | 8 | Octet to the system |
| prbs_sync_o | output | 1 | PRBS checker loaded |
| prbs_err_o | output | 16 | PRBS mismatch count |

## Verification
A corrupted control word shows at the ports on the next octet of that slot, one clock after it is presented. That octet takes the wrong source, has the wrong inversion or the wrong LSB, and sweeping all 24 slots over a full superframe in several configurations exposes it within one pass. A wrong PRBS generator state shows in the next pattern octet, and a wrong milliwatt phase shows at the first test octet after a slot-23 boundary. A checker fault shows as a nonzero count on a clean looped pattern, or as the wrong count after a single flipped bit, which must produce exactly three mismatches.

// File: rtl/t1_slot_pkg.sv
package t1_slot_pkg;

  typedef struct packed {
    logic msg;
    logic inv;
    logic rem_lb;
    logic loc_lb;
    logic tx_test;
    logic rx_test;
    logic sig_ram;
    logic clear;
  } slot_ctl_t;

  localparam int unsigned PRBS_W = 15;

  function automatic logic [7:0] dmw_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx[1:0])
      2'd0, 2'd3: b = 8'h1E;
      default:    b = 8'h0B;
    endcase
    // second half of the period is the sign-flipped first half
    b[7] = idx[2];
    return b;
  endfunction

  function automatic logic [7:0] prbs_octet(input logic [PRBS_W-1:0] s);
    logic [PRBS_W-1:0] t;
    logic [7:0]        o;
    t = s;
    o = '0;
    for (int i = 7; i >= 0; i--) begin
      o[i] = t[14] ^ t[13];
      t    = {t[13:0], o[i]};
    end
    return o;
  endfunction

  function automatic logic [PRBS_W-1:0] prbs_adv8(input logic [PRBS_W-1:0] s);
    logic [PRBS_W-1:0] t;
    t = s;
    for (int i = 0; i < 8; i++) t = {t[13:0], t[14] ^ t[13]};
    return t;
  endfunction

endpackage

// File: rtl/t1_slot_cfg.sv
module t1_slot_cfg
  import t1_slot_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 24,
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              ctl_page_i,
  input  logic [ADDR_W-1:0] ctl_addr_i,
  input  logic [7:0]        ctl_wdata_i,
  input  logic              sig_we_i,
  input  logic [SLOT_W-1:0] sig_slot_i,
  input  logic [1:0]        sig_wdata_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output slot_ctl_t         rd_ctl_o,
  output logic [1:0]        rd_sig_o
);

  localparam int unsigned       PAGE_SZ = 1 << ADDR_W;
  localparam logic [SLOT_W-1:0] LAST    = SLOT_W'(NUM_SLOTS - 1);

  logic [NUM_SLOTS-1:0][7:0] ctl_q;
  logic [NUM_SLOTS-1:0][1:0] sig_q;
  logic [SLOT_W-1:0]         wr_slot;
  logic                      ctl_hit, sig_hit;

  // second page starts one page size further; unused offsets fall past LAST
  assign wr_slot = ctl_page_i ? SLOT_W'(PAGE_SZ + 32'(ctl_addr_i)) : SLOT_W'(ctl_addr_i);
  assign ctl_hit = ctl_we_i && (wr_slot <= LAST);
  assign sig_hit = sig_we_i && (sig_slot_i <= LAST);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_q[g] <= '0;
        sig_q[g] <= '0;
      end else begin
        if (ctl_hit && wr_slot == SLOT_W'(g)) ctl_q[g] <= ctl_wdata_i;
        if (sig_hit && sig_slot_i == SLOT_W'(g)) sig_q[g] <= sig_wdata_i;
      end
    end
  end

  always_comb begin
    rd_ctl_o = '0;
    rd_sig_o = '0;
    if (rd_slot_i <= LAST) begin
      rd_ctl_o = slot_ctl_t'(ctl_q[rd_slot_i]);
      rd_sig_o = sig_q[rd_slot_i];
    end
  end

  assert_hole_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && ctl_page_i && ctl_addr_i >= ADDR_W'(NUM_SLOTS - PAGE_SZ)) |=> $stable(ctl_q));

  assert_page_map_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !ctl_page_i) |=> ctl_q[$past(ctl_addr_i)] == $past(ctl_wdata_i));

endmodule

// File: rtl/t1_prbs_gen.sv
module t1_prbs_gen
  import t1_slot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  output logic [7:0] octet_o
);

  logic [PRBS_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '1;
    else if (adv_i) state_q <= prbs_adv8(state_q);
  end

  assign octet_o = prbs_octet(state_q);

  assert_never_lockup_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

endmodule

// File: rtl/t1_prbs_chk.sv
module t1_prbs_chk
  import t1_slot_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [7:0]       octet_i,
  output logic             sync_o,
  output logic [CNT_W-1:0] err_o
);

  logic [PRBS_W-1:0] sh_q, sh_d;
  logic [3:0]        fill_q, fill_d;
  logic [3:0]        miss;
  logic [CNT_W-1:0]  err_q, err_d;
  logic [CNT_W:0]    sum;

  always_comb begin
    sh_d   = sh_q;
    fill_d = fill_q;
    miss   = '0;
    for (int i = 7; i >= 0; i--) begin
      if (fill_d == 4'(PRBS_W)) begin
        if (octet_i[i] != (sh_d[14] ^ sh_d[13])) miss = miss + 4'd1;
      end else begin
        fill_d = fill_d + 4'd1;
      end
      sh_d = {sh_d[13:0], octet_i[i]};
    end
    sum   = {1'b0, err_q} + (CNT_W+1)'(miss);
    err_d = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      fill_q <= '0;
      err_q  <= '0;
    end else if (en_i) begin
      sh_q   <= sh_d;
      fill_q <= fill_d;
      err_q  <= err_d;
    end
  end

  assign sync_o = (fill_q == 4'(PRBS_W));
  assign err_o  = err_q;

  assert_sync_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(sync_o));

  assert_err_monotonic_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o >= $past(err_o));

  assert_err_step_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o - $past(err_o)) <= CNT_W'(8));

  assert_no_count_unsynced_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sync_o) |-> err_o == $past(err_o));

endmodule

// File: rtl/t1_slot_ctrl.sv
module t1_slot_ctrl
  import t1_slot_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 24,
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned FRAME_W   = 4,
  parameter int unsigned ROB_A_FR  = 5,
  parameter int unsigned ROB_B_FR  = 11,
  parameter int unsigned CNT_W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctl_we_i,
  input  logic               ctl_page_i,
  input  logic [ADDR_W-1:0]  ctl_addr_i,
  input  logic [7:0]         ctl_wdata_i,
  input  logic               msg_we_i,
  input  logic [7:0]         msg_wdata_i,
  input  logic               sig_we_i,
  input  logic [SLOT_W-1:0]  sig_slot_i,
  input  logic [1:0]         sig_wdata_i,
  input  logic               test_sel_i,
  input  logic               oct_valid_i,
  input  logic [SLOT_W-1:0]  oct_slot_i,
  input  logic [FRAME_W-1:0] oct_frame_i,
  input  logic [7:0]         sys_tx_i,
  input  logic [7:0]         line_rx_i,
  input  logic [1:0]         sig_ser_i,
  output logic               oct_valid_o,
  output logic [7:0]         line_tx_o,
  output logic [7:0]         sys_rx_o,
  output logic               prbs_sync_o,
  output logic [CNT_W-1:0]   prbs_err_o
);

  localparam logic [SLOT_W-1:0]  LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [FRAME_W-1:0] FR_A      = FRAME_W'(ROB_A_FR);
  localparam logic [FRAME_W-1:0] FR_B      = FRAME_W'(ROB_B_FR);

  slot_ctl_t  ctl;
  logic [1:0] ram_sig, sig_src;
  logic [7:0] msg_q;
  logic [2:0] dmw_ph_q;
  logic [7:0] dmw, prbs_oct, pattern, tx_pre, tx_byte, rx_src, rx_byte;
  logic       robbed, rob_bit, gen_adv, chk_en;

  t1_slot_cfg #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .ctl_we_i, .ctl_page_i, .ctl_addr_i, .ctl_wdata_i,
    .sig_we_i, .sig_slot_i, .sig_wdata_i,
    .rd_slot_i (oct_slot_i),
    .rd_ctl_o  (ctl),
    .rd_sig_o  (ram_sig)
  );

  t1_prbs_gen u_gen (
    .clk_i, .rst_ni,
    .adv_i   (gen_adv),
    .octet_o (prbs_oct)
  );

  t1_prbs_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i, .rst_ni,
    .en_i    (chk_en),
    .octet_i (rx_src),
    .sync_o  (prbs_sync_o),
    .err_o   (prbs_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_q    <= '0;
      dmw_ph_q <= '0;
    end else begin
      if (msg_we_i) msg_q <= msg_wdata_i;
      if (oct_valid_i && oct_slot_i == LAST_SLOT) dmw_ph_q <= dmw_ph_q + 3'd1;
    end
  end

  assign dmw     = dmw_byte(dmw_ph_q);
  assign pattern = test_sel_i ? dmw : prbs_oct;

  always_comb begin
    if (ctl.rem_lb)       tx_pre = line_rx_i;
    else if (ctl.tx_test) tx_pre = pattern;
    else if (ctl.msg)     tx_pre = msg_q;
    else                  tx_pre = sys_tx_i ^ {8{ctl.inv}};

    robbed  = !ctl.clear && (oct_frame_i == FR_A || oct_frame_i == FR_B);
    sig_src = ctl.sig_ram ? ram_sig : sig_ser_i;
    rob_bit = (oct_frame_i == FR_A) ? sig_src[1] : sig_src[0];
    tx_byte = robbed ? {tx_pre[7:1], rob_bit} : tx_pre;

    rx_src  = ctl.loc_lb ? tx_byte : line_rx_i;
    rx_byte = (ctl.rx_test && test_sel_i) ? dmw : (rx_src ^ {8{ctl.inv}});
  end

  assign gen_adv = oct_valid_i && ctl.tx_test && !ctl.rem_lb && !test_sel_i;
  assign chk_en  = oct_valid_i && ctl.rx_test && !test_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oct_valid_o <= 1'b0;
      line_tx_o   <= '0;
      sys_rx_o    <= '0;
    end else begin
      oct_valid_o <= oct_valid_i;
      if (oct_valid_i) begin
        line_tx_o <= tx_byte;
        sys_rx_o  <= rx_byte;
      end
    end
  end

  assert_valid_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oct_valid_i |=> oct_valid_o);

  assert_idle_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oct_valid_i |=> !oct_valid_o);

  assert_plain_path_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oct_valid_i && ctl.clear && !ctl.rem_lb && !ctl.tx_test && !ctl.msg)
      |=> line_tx_o == $past(sys_tx_i ^ {8{ctl.inv}}));

  assert_remote_lb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oct_valid_i && ctl.clear && ctl.rem_lb) |=> line_tx_o == $past(line_rx_i));

  assert_rob_a_ram_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oct_valid_i && !ctl.clear && ctl.sig_ram && oct_frame_i == FR_A)
      |=> line_tx_o[0] == $past(ram_sig[1]));

  assert_no_rob_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oct_valid_i && ctl.clear && !ctl.rem_lb && !ctl.tx_test && ctl.msg)
      |=> line_tx_o == $past(msg_q));

endmodule

// File: tb/tb_t1_slot_ctrl.sv
module tb_t1_slot_ctrl;
  localparam int CLK_NS = 10;
  localparam int NS     = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, ctl_page = 0, msg_we = 0, sig_we = 0, test_sel = 0, oct_valid = 0;
  logic [3:0] ctl_addr = 0, oct_frame = 0;
  logic [7:0] ctl_wdata = 0, msg_wdata = 0, sys_tx = 0, line_rx = 0;
  logic [4:0] sig_slot = 0, oct_slot = 0;
  logic [1:0] sig_wdata = 0, sig_ser = 0;
  logic       oct_valid_o, prbs_sync;
  logic [7:0] line_tx, sys_rx;
  logic [15:0] prbs_err;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0]  ctl_m [NS];
  logic [1:0]  sig_m [NS];
  logic [7:0]  msg_m = 0;
  logic [2:0]  ph_m = 0;
  logic [14:0] pg_m = '1;
  logic [7:0]  last_tx;

  t1_slot_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_page_i(ctl_page), .ctl_addr_i(ctl_addr), .ctl_wdata_i(ctl_wdata),
    .msg_we_i(msg_we), .msg_wdata_i(msg_wdata),
    .sig_we_i(sig_we), .sig_slot_i(sig_slot), .sig_wdata_i(sig_wdata),
    .test_sel_i(test_sel), .oct_valid_i(oct_valid), .oct_slot_i(oct_slot),
    .oct_frame_i(oct_frame), .sys_tx_i(sys_tx), .line_rx_i(line_rx), .sig_ser_i(sig_ser),
    .oct_valid_o(oct_valid_o), .line_tx_o(line_tx), .sys_rx_o(sys_rx),
    .prbs_sync_o(prbs_sync), .prbs_err_o(prbs_err)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [7:0] dmw_ref(input logic [2:0] i);
    logic [7:0] t [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};
    return t[i];
  endfunction

  function automatic logic [7:0] pbyte(input logic [14:0] s);
    logic [7:0] o;
    for (int k = 0; k < 8; k++) begin
      o[7-k] = s[14] ^ s[13];
      s = {s[13:0], o[7-k]};
    end
    return o;
  endfunction

  function automatic logic [14:0] pnext(input logic [14:0] s);
    for (int k = 0; k < 8; k++) s = {s[13:0], s[14] ^ s[13]};
    return s;
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  // R1: page/offset placement of a slot's word
  task automatic wr_ctl(input int slot, input logic [7:0] d);
    @(negedge clk);
    ctl_we = 1; ctl_page = (slot >= 16); ctl_addr = 4'(slot % 16); ctl_wdata = d;
    @(negedge clk);
    ctl_we = 0;
    ctl_m[slot] = d;
  endtask

  task automatic wr_raw(input logic pg, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    ctl_we = 1; ctl_page = pg; ctl_addr = a; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic wr_sig(input int slot, input logic [1:0] d);
    @(negedge clk);
    sig_we = 1; sig_slot = 5'(slot); sig_wdata = d;
    @(negedge clk);
    sig_we = 0;
    sig_m[slot] = d;
  endtask

  task automatic wr_msg(input logic [7:0] d);
    @(negedge clk);
    msg_we = 1; msg_wdata = d;
    @(negedge clk);
    msg_we = 0;
    msg_m = d;
  endtask

  task automatic send(input int slot, input int frame, input logic [7:0] sys,
                      input logic [7:0] rx, input logic [1:0] ser, input string force_tag);
    logic [7:0] c, txe, rxe, src;
    logic [1:0] s;
    string ttag, rtag;
    @(negedge clk);
    oct_valid = 1; oct_slot = 5'(slot); oct_frame = 4'(frame);
    sys_tx = sys; line_rx = rx; sig_ser = ser;
    c = ctl_m[slot];
    if (c[5])      begin txe = rx;  ttag = "R5"; end
    else if (c[3]) begin txe = test_sel ? dmw_ref(ph_m) : pbyte(pg_m); ttag = test_sel ? "R7_R12" : "R7_R13"; end
    else if (c[7]) begin txe = msg_m; ttag = "R4"; end
    else           begin txe = sys ^ {8{c[6]}}; ttag = "R3"; end
    if (!c[0] && (frame == 5 || frame == 11)) begin
      s = c[1] ? sig_m[slot] : ser;
      txe[0] = (frame == 5) ? s[1] : s[0];
      ttag = "R9";
    end
    src = c[4] ? txe : rx;
    if (c[2] && test_sel) begin rxe = dmw_ref(ph_m); rtag = "R8_R12"; end
    else begin rxe = src ^ {8{c[6]}}; rtag = c[4] ? "R6" : "R3"; end
    if (force_tag != "") begin ttag = force_tag; rtag = force_tag; end
    @(posedge clk);
    if (c[3] && !c[5] && !test_sel) pg_m = pnext(pg_m);
    if (slot == NS - 1) ph_m = ph_m + 3'd1;
    @(negedge clk);
    chk("R11", "valid_o", int'(oct_valid_o), 1);
    chk(ttag, $sformatf("tx slot=%0d fr=%0d ctl=%02h", slot, frame, c), int'(line_tx), int'(txe));
    chk(rtag, $sformatf("rx slot=%0d fr=%0d ctl=%02h", slot, frame, c), int'(sys_rx), int'(rxe));
    last_tx = line_tx;
    oct_valid = 0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R11 got=timeout exp=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pkt;
    for (int i = 0; i < NS; i++) begin ctl_m[i] = 0; sig_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "reset valid_o", int'(oct_valid_o), 0);
    chk("R3", "reset line_tx", int'(line_tx), 0);
    chk("R3", "reset sys_rx", int'(sys_rx), 0);
    chk("R10", "reset sync", int'(prbs_sync), 0);
    chk("R10", "reset err", int'(prbs_err), 0);

    // R2: writes to unused second-page offsets leave every word at zero
    for (int a = 8; a < 16; a++) wr_raw(1'b1, 4'(a), 8'hFF);
    for (int sl = 0; sl < NS; sl++) send(sl, 0, 8'(sl * 11 + 3), 8'(sl * 7 + 1), 2'b00, "R2");
    @(negedge clk);
    chk("R11", "idle valid_o", int'(oct_valid_o), 0);

    for (int sl = 0; sl < NS; sl++) wr_sig(sl, 2'(sl % 4));

    // R1,R3..R9,R12,R13: sweep words over all slots and a full superframe
    for (int k = 0; k < 6; k++) begin
      test_sel = k[0];
      wr_msg(8'(8'h5A + k * 17));
      for (int sl = 0; sl < NS; sl++) begin
        logic [7:0] w;
        w = 8'(sl * 37 + k * 91 + 13);
        if (!test_sel) w[2] = 1'b0;
        wr_ctl(sl, w);
      end
      for (int fr = 0; fr < 12; fr++)
        for (int sl = 0; sl < NS; sl++)
          send(sl, fr, 8'(sl * 29 + fr * 5 + k), 8'(sl * 13 + fr * 71 + k * 3), 2'((sl + fr) % 4), "");
    end

    // R8,R10,R13: loop PRBS from slot 5 into checker on slot 2
    test_sel = 0;
    wr_ctl(5, 8'h09);
    wr_ctl(2, 8'h04);
    send(5, 0, 8'h00, 8'h00, 2'b00, "");
    send(2, 0, 8'h00, last_tx, 2'b00, "");
    chk("R10", "sync after 8 bits", int'(prbs_sync), 0);
    send(5, 0, 8'h00, 8'h00, 2'b00, "");
    send(2, 0, 8'h00, last_tx, 2'b00, "");
    chk("R10", "sync after 16 bits", int'(prbs_sync), 1);
    for (int n = 0; n < 4; n++) begin
      send(5, 0, 8'h00, 8'h00, 2'b00, "");
      send(2, 0, 8'h00, last_tx, 2'b00, "");
    end
    chk("R8", "clean loop err", int'(prbs_err), 0);
    send(5, 0, 8'h00, 8'h00, 2'b00, "");
    pkt = last_tx ^ 8'h10;
    send(2, 0, 8'h00, pkt, 2'b00, "");
    for (int n = 0; n < 3; n++) begin
      send(5, 0, 8'h00, 8'h00, 2'b00, "");
      send(2, 0, 8'h00, last_tx, 2'b00, "");
    end
    chk("R10", "single flip err", int'(prbs_err), 3);
    chk("R10", "sync held", int'(prbs_sync), 1);

    // R10: saturation
    for (int n = 0; n < 8300; n++) send(2, 0, 8'h00, 8'hFF, 2'b00, "");
    chk("R10", "saturated err", int'(prbs_err), 65535);
    send(2, 0, 8'h00, 8'hFF, 2'b00, "");
    chk("R10", "held at saturation", int'(prbs_err), 65535);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule